// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a loop over a run-time element count into a series of vector-sized pieces. A start pulse hands it the total count and three byte base addresses: two source streams and one destination stream. It then issues one command per piece. Each command carries the piece's element count, which is the value for the vector-length register, and the current address of each stream. The execution side accepts a command through a valid/ready handshake and reports with a one-cycle completion pulse when the piece is finished. Only after that pulse does the sequencer bump its pointers and issue the next piece.

The leftover that does not fill a whole vector register goes first, so that every later piece runs at the full register length. Each pointer moves forward by the element count of the piece just finished, times the element size in bytes. The run ends when nothing remains. A busy flag covers the whole run, and a one-cycle done pulse marks its end.

Top module: `strip_mine_seq`

## Requirements
- R1: Every command's length lies between 1 and the maximum vector length (64 by default); no command ever carries a larger value or zero.
- R2: When the total count N is not a multiple of 64, the first command's length is N mod 64.
- R3: Every command after the first has length 64; when N is a nonzero multiple of 64, every command, including the first, has length 64.
- R4: The first command carries the three base addresses as loaded. Each later command carries each address advanced by the sum of all earlier lengths times 8 bytes.
- R5: The lengths of a run add up to exactly N, and the run issues ceil(N/64) commands.
- R6: A start with N = 0 issues no command, leaves busy low and raises done for exactly one cycle, in the cycle after the start is taken.
- R7: While a command is valid and not accepted, its valid and payload hold steady. After acceptance, no new command appears until the segment-complete pulse arrives.
- R8: Busy rises in the cycle after a start with N > 0 and falls in the cycle after the completion pulse of the last segment. Done pulses for one cycle in that same cycle and is never high while busy is high.
- R9: A start pulse that arrives while busy has no effect on the lengths or addresses of the commands that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads count and bases when idle |
| total_i | input | CNT_W (16) | Total element count N |
| base_a_i | input | ADDR_W (32) | First source base byte address |
| base_b_i | input | ADDR_W (32) | Second source base byte address |
| base_c_i | input | ADDR_W (32) | Destination base byte address |
| cmd_valid_o | output | 1 | Segment command valid |
| cmd_ready_i | input | 1 | Execution side accepts command |
| cmd_len_o | output | LEN_W (7) | Segment length for the vector-length register |
| cmd_a_o | output | ADDR_W (32) | Current first source address |
| cmd_b_o | output | ADDR_W (32) | Current second source address |
| cmd_c_o | output | ADDR_W (32) | Current destination address |
| seg_done_i | input | 1 | Execution side finished the accepted segment |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
Every count from 0 to 300 is run, so the bench sees zero, counts below one register length, exact multiples (64, 128, 192, 256) and values one above and below them. These cases show whether the remainder-first rule and the skipping of an empty first segment are handled correctly. Large counts (1000, 65535) check that the full-length pieces chain for many segments and that the pointers build up correctly. Runs where ready is held low, and runs where a start pulse is injected between acceptance and completion, show whether the payload holds steady and whether a mid-run start is ignored.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sm_seg_len.sv
module sm_seg_len #(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(MVL + 1),
  localparam int MOD_W = $clog2(MVL)
) (
  input  logic [CNT_W-1:0] rem_i,
  output logic [LEN_W-1:0] len_o
);
  logic [MOD_W-1:0] low;

  // MVL is a power of two: remainder is the low bits of the count
  assign low = rem_i[MOD_W-1:0];

  always_comb begin
    if (low == '0) len_o = LEN_W'(MVL);
    else           len_o = LEN_W'(low);
  end
endmodule

// File: rtl/sm_ptr_bank.sv
module sm_ptr_bank #(
  parameter int NPTR       = 3,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 7,
  parameter int ELEM_BYTES = 8,
  localparam int SHIFT = $clog2(ELEM_BYTES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         adv_i,
  input  logic [NPTR-1:0][ADDR_W-1:0]  base_i,
  input  logic [LEN_W-1:0]             len_i,
  output logic [NPTR-1:0][ADDR_W-1:0]  ptr_o
);
  logic [ADDR_W-1:0] step;

  assign step = ADDR_W'(len_i) << SHIFT;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q <= '0;
      else if (load_i) ptr_q <= base_i[g];
      else if (adv_i)  ptr_q <= ptr_q + step;
    end
    assign ptr_o[g] = ptr_q;
  end

  assert_load_adv_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl
  import sm_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             cmd_ready_i,
  input  logic             seg_done_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             cmd_valid_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] rem_q;
  logic             done_q;
  logic             last_seg;
  logic             take_start;

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign last_seg   = (rem_q == CNT_W'(len_i));
  assign adv_o      = (state_q == ST_WAIT) && seg_done_i;
  assign load_o     = take_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && total_i != '0) state_d = ST_ISSUE;
      ST_ISSUE: if (cmd_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (seg_done_i) state_d = last_seg ? ST_IDLE : ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (take_start && total_i == '0) || (adv_o && last_seg);
      if (take_start) rem_q <= total_i;
      else if (adv_o) rem_q <= rem_q - CNT_W'(len_i);
    end
  end

  assign rem_o       = rem_q;
  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  assert_len_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (len_i != '0 && len_i <= LEN_W'(MVL)));
  assert_rem_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q != '0);
  assert_valid_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o);
  assert_reissue_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_valid_o) && $past(busy_o)) |-> $past(seg_done_i));
  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(start_i));
endmodule

// File: rtl/strip_mine_seq.sv
module strip_mine_seq #(
  parameter int MVL        = 64,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8,
  localparam int LEN_W = $clog2(MVL + 1),
  localparam int NPTR  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] base_c_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [ADDR_W-1:0] cmd_a_o,
  output logic [ADDR_W-1:0] cmd_b_o,
  output logic [ADDR_W-1:0] cmd_c_o,
  input  logic              seg_done_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [CNT_W-1:0]                rem;
  logic [LEN_W-1:0]                len;
  logic                            load, adv;
  logic [NPTR-1:0][ADDR_W-1:0]     bases, ptrs;

  assign bases = {base_c_i, base_b_i, base_a_i};

  sm_seg_len #(.MVL(MVL), .CNT_W(CNT_W)) u_len (
    .rem_i (rem),
    .len_o (len)
  );

  sm_ctrl #(.MVL(MVL), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .total_i     (total_i),
    .cmd_ready_i (cmd_ready_i),
    .seg_done_i  (seg_done_i),
    .len_i       (len),
    .rem_o       (rem),
    .load_o      (load),
    .adv_o       (adv),
    .cmd_valid_o (cmd_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  sm_ptr_bank #(.NPTR(NPTR), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ELEM_BYTES(ELEM_BYTES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .base_i (bases),
    .len_i  (len),
    .ptr_o  (ptrs)
  );

  assign cmd_len_o = len;
  assign cmd_a_o   = ptrs[0];
  assign cmd_b_o   = ptrs[1];
  assign cmd_c_o   = ptrs[2];

  assert_payload_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      ($stable(cmd_len_o) && $stable(cmd_a_o) && $stable(cmd_b_o) && $stable(cmd_c_o)));
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);
endmodule

// File: tb/tb_strip_mine_seq.sv
module tb_strip_mine_seq;
  localparam int MVL = 64;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 32;
  localparam int LEN_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  total = '0;
  logic [ADDR_W-1:0] ba = '0, bb = '0, bc = '0;
  logic              cmd_valid, cmd_ready = 1'b0, seg_done = 1'b0;
  logic [LEN_W-1:0]  cmd_len;
  logic [ADDR_W-1:0] ca, cb, cc;
  logic              busy, done;

  int total_chk = 0;
  int bad = 0;

  always #5 clk = ~clk;

  strip_mine_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_i(total),
    .base_a_i(ba), .base_b_i(bb), .base_c_i(bc),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_len_o(cmd_len),
    .cmd_a_o(ca), .cmd_b_o(cb), .cmd_c_o(cc),
    .seg_done_i(seg_done), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total_chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input int n, input bit stall, input bit probe);
    int rem, consumed, exp_len, segs, exp_segs, sum;
    logic [ADDR_W-1:0] a0, b0, c0;
    a0 = 32'h1000_0000 + n * 16;
    b0 = 32'h2000_0008 + n * 24;
    c0 = 32'h3000_0000 - n * 8;
    @(negedge clk);
    total = CNT_W'(n); ba = a0; bb = b0; bc = c0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R6 done", done, 1);
      chk(busy == 1'b0, "R6 busy", busy, 0);
      chk(cmd_valid == 1'b0, "R6 valid", cmd_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R6 done width", done, 0);
      return;
    end
    chk(busy == 1'b1, "R8 busy rise", busy, 1);
    rem = n; consumed = 0; segs = 0; sum = 0;
    exp_segs = (n + MVL - 1) / MVL;
    while (rem > 0) begin
      exp_len = (segs == 0 && (n % MVL) != 0) ? (n % MVL) : MVL;
      chk(cmd_valid == 1'b1, "R7 valid", cmd_valid, 1);
      chk(int'(cmd_len) == exp_len, segs == 0 ? "R2 first len" : "R3 full len", cmd_len, exp_len);
      chk(cmd_len != 0 && int'(cmd_len) <= MVL, "R1 bound", cmd_len, MVL);
      chk(ca == a0 + consumed * 8, "R4 addr a", ca, a0 + consumed * 8);
      chk(cb == b0 + consumed * 8, "R4 addr b", cb, b0 + consumed * 8);
      chk(cc == c0 + consumed * 8, "R4 addr c", cc, c0 + consumed * 8);
      if (stall) begin
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk(cmd_valid == 1'b1, "R7 hold valid", cmd_valid, 1);
          chk(int'(cmd_len) == exp_len, "R7 hold len", cmd_len, exp_len);
          chk(ca == a0 + consumed * 8, "R7 hold addr", ca, a0 + consumed * 8);
        end
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(cmd_valid == 1'b0, "R7 no reissue", cmd_valid, 0);
      if (probe) begin
        total = CNT_W'(n + 7); ba = 32'hDEAD_0000; bb = 32'hBEEF_0000; bc = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy kept", busy, 1);
      end
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R7 wait for done", cmd_valid, 0);
      seg_done = 1'b1;
      @(negedge clk);
      seg_done = 1'b0;
      sum += exp_len; consumed += exp_len; rem -= exp_len; segs++;
      if (rem > 0) begin
        chk(busy == 1'b1, "R8 busy mid", busy, 1);
        chk(done == 1'b0, "R8 no early done", done, 0);
      end
    end
    chk(sum == n, "R5 sum", sum, n);
    chk(segs == exp_segs, "R5 count", segs, exp_segs);
    chk(busy == 1'b0, "R8 busy fall", busy, 0);
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(cmd_valid == 1'b0, "R8 idle valid", cmd_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "reset busy", busy, 0);
    chk(cmd_valid == 1'b0, "reset valid", cmd_valid, 0);
    chk(done == 1'b0, "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n <= 300; n++) run_case(n, (n % 3) == 0, (n % 2) == 1);
    run_case(1000, 1'b0, 1'b1);
    run_case(65535, 1'b0, 1'b0);
    run_case(0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total_chk, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total_chk, bad);
    $finish;
  end
endmodule